// File: doc/BRIEF.md
# Keyed-Reload Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. Software programs a reload value and turns the watchdog on. After that it must keep writing a fixed two-write key sequence to a dedicated register, or the block pulses its reset output. The clock is divided by a fixed prescaler, and each prescaled tick lowers a 24-bit down-counter by one. Software can read the live counter to work out how much time is left: remaining time is the count times the prescale ratio, divided by the clock rate.

Enabling the timer is a two-step act. Setting the enable bit does nothing on its own. The counter only starts, and the reset path only becomes live, once a complete key sequence has been written after the enable. From that point the timer is armed and cannot be turned off by software. The key sequence also acts as a tripwire. When reset mode is on and the timer is armed, any disturbance after the first key byte causes an immediate reset pulse. A disturbance is a wrong second byte or any bus write to another register.

Top module: `wdg_timer`

## Requirements
- R1: Register offsets: mode 0x0, reload value 0x4, key 0x8, live count 0xC (read-only). In the mode register, bit 0 is enable, bit 1 selects reset on expiry, and bit 2 is a read-only expiry flag. After reset, mode reads 0, the reload value reads 0xFF, the count reads 0xFF and the reset output is low.
- R2: A valid key sequence is a write whose low byte is 0xAA to the key register, with the next bus write being a write whose low byte is 0x55 to the key register. Idle cycles may come in between. The sequence copies the reload value into the counter, and the new count is readable in the cycle after the second write.
- R3: While armed, the counter drops by one every 4 clocks. The first decrement happens 4 clocks after the key sequence completes, because completion restarts the prescaler.
- R4: With enable set but no key sequence completed since, the counter does not move and no reset pulse is produced.
- R5: When armed with reset mode set, a tick that finds the counter at 0 produces a reset pulse exactly one clock wide. This happens 4*(reload+1) clocks after the last key sequence. The counter is reloaded at the same time.
- R6: When armed with reset mode clear, the same expiry produces no pulse. Instead it sets the expiry flag (mode bit 2), which stays set until system reset, and the counter reloads and keeps running.
- R7: When armed with reset mode set, the following each give a reset pulse in the cycle after the offending write: after 0xAA has been accepted, either a key write whose low byte is not 0x55, or any write to another register.
- R8: A broken sequence while not armed, or while reset mode is clear, gives no pulse. The half-entered sequence is dropped, so a lone 0x55 afterwards does not reload.
- R9: Before arming, enable and reset mode can be written both to 1 and to 0. Once armed, writing 0 to either bit has no effect.
- R10: A write to the reload register keeps the low 24 bits and clamps any value below 0xFF up to 0xFF. The new value reaches the counter only at the next key sequence.
- R11: A key sequence that completes on the same clock as an expiry wins: no pulse, and the counter reloads from that clock.
- R12: When no 0xAA is pending, a key-register write with any other low byte is ignored, even when armed with reset mode set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Register byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from bus_addr |
| wdt_rst_o | output | 1 | One-clock reset request pulse |

## Verification
The counter's expiry and the completion of a key sequence can land on the same clock edge. The bench arranges this by timing the second key write to be sampled on the exact edge where expiry is due, 4*(reload+1) edges after the previous feed. It then expects no pulse, a freshly reloaded count, and a next expiry a full period later. A scoreboard queue holds the edge index of every expected reset pulse. A monitor compares that queue against the output on every cycle, so a missing pulse, a late pulse, a stretched pulse or a stray pulse is each reported.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam int OFS_MODE = 'h0;
   localparam int OFS_TC   = 'h4;
   localparam int OFS_KEY  = 'h8;
   localparam int OFS_CNT  = 'hC;

   localparam int MODE_EN_BIT   = 0;
   localparam int MODE_RST_BIT  = 1;
   localparam int MODE_FLAG_BIT = 2;

   typedef enum logic {
      SEQ_IDLE,
      SEQ_KEYED
   } seq_state_t;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   if (DIV < 1) begin : g_bad_div
      $error("wdg_prescaler: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      logic unused_pass;
      assign unused_pass = ^{clk, rst_n, restart};
      assign tick = run;
   end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] ph_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         ph_q <= '0;
         else if (restart)   ph_q <= '0;
         else if (run)       ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
      end

      assign tick = run && (ph_q == LAST);

      // R3
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

// File: rtl/wdg_keyseq.sv
module wdg_keyseq
   import wdg_pkg::*;
#(
   parameter int          KW    = 8,
   parameter logic [KW-1:0] KEY_A = 8'hAA,
   parameter logic [KW-1:0] KEY_B = 8'h55
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_key,
   input  logic          wr_other,
   input  logic [KW-1:0] key,
   output logic          good,
   output logic          bad
);
   if (KEY_A == KEY_B) begin : g_bad_keys
      $error("wdg_keyseq: the two key values must differ");
   end

   seq_state_t st_q;
   logic       keyed;

   assign keyed = (st_q == SEQ_KEYED);
   assign good  = keyed && wr_key && (key == KEY_B);
   assign bad   = keyed && (wr_other || (wr_key && (key != KEY_B)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= SEQ_IDLE;
      end else if (keyed) begin
         if (wr_key || wr_other) st_q <= SEQ_IDLE;
      end else if (wr_key && (key == KEY_A)) begin
         st_q <= SEQ_KEYED;
      end
   end

   // R2
   key_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      good |=> !good);
   // R7
   key_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (good || bad) |=> (st_q == SEQ_IDLE));
endmodule

// File: rtl/wdg_downcnt.sv
module wdg_downcnt #(
   parameter int          W       = 24,
   parameter logic [W-1:0] RST_VAL = 24'hFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reload,
   input  logic         tick,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count,
   output logic         at_zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= RST_VAL;
      else if (reload)                  cnt_q <= load_val;
      else if (tick && (cnt_q != '0))   cnt_q <= cnt_q - 1'b1;
   end

   assign count   = cnt_q;
   assign at_zero = (cnt_q == '0);

   // R4
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && !tick) |=> $stable(count));
   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !reload && !at_zero) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
   import wdg_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 24,
   parameter int PRESC  = 4,
   parameter int TC_MIN = 'hFF,
   parameter int KEY_W  = 8,
   parameter logic [KEY_W-1:0] KEY_A = 8'hAA,
   parameter logic [KEY_W-1:0] KEY_B = 8'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wdt_rst_o
);
   localparam logic [CNT_W-1:0] TC_FLOOR = CNT_W'(TC_MIN);

   if (ADDR_W < 4) begin : g_bad_addr
      $error("wdg_timer: ADDR_W must cover offset 0xC");
   end
   if (DATA_W <= CNT_W || KEY_W > CNT_W) begin : g_bad_data
      $error("wdg_timer: DATA_W must exceed CNT_W and KEY_W must fit in it");
   end
   if (TC_MIN < 1 || TC_MIN >= (2 ** CNT_W)) begin : g_bad_min
      $error("wdg_timer: TC_MIN must fit in the counter");
   end

   // bus decode
   logic wr, hit_mode, hit_tc, hit_key;
   assign wr       = bus_sel && bus_wr;
   assign hit_mode = (bus_addr == ADDR_W'(OFS_MODE));
   assign hit_tc   = (bus_addr == ADDR_W'(OFS_TC));
   assign hit_key  = (bus_addr == ADDR_W'(OFS_KEY));

   logic unused_hi;
   assign unused_hi = ^bus_wdata[DATA_W-1:CNT_W];

   // state
   logic             en_q, rstm_q, flag_q, armed_q, rst_q;
   logic [CNT_W-1:0] tc_q;
   logic [CNT_W-1:0] count;
   logic             at_zero, tick, good, bad, expire, reload;
   logic [CNT_W-1:0] tc_in;

   wdg_keyseq #(.KW(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_keyseq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_key   (wr && hit_key),
      .wr_other (wr && !hit_key),
      .key      (bus_wdata[KEY_W-1:0]),
      .good     (good),
      .bad      (bad)
   );

   wdg_prescaler #(.DIV(PRESC)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (armed_q),
      .restart (good),
      .tick    (tick)
   );

   assign expire = armed_q && tick && at_zero && !good;
   assign reload = good || expire;

   wdg_downcnt #(.W(CNT_W), .RST_VAL(TC_FLOOR)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .reload   (reload),
      .tick     (tick),
      .load_val (tc_q),
      .count    (count),
      .at_zero  (at_zero)
   );

   assign tc_in = bus_wdata[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         rstm_q  <= 1'b0;
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
         rst_q   <= 1'b0;
         tc_q    <= TC_FLOOR;
      end else begin
         if (wr && hit_mode) begin
            if (armed_q) begin
               en_q   <= en_q   | bus_wdata[MODE_EN_BIT];
               rstm_q <= rstm_q | bus_wdata[MODE_RST_BIT];
            end else begin
               en_q   <= bus_wdata[MODE_EN_BIT];
               rstm_q <= bus_wdata[MODE_RST_BIT];
            end
         end
         if (wr && hit_tc)
            tc_q <= (tc_in < TC_FLOOR) ? TC_FLOOR : tc_in;
         if (good && en_q)
            armed_q <= 1'b1;
         if (expire && !rstm_q)
            flag_q <= 1'b1;
         rst_q <= rstm_q && (expire || (bad && armed_q));
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_mode) begin
         bus_rdata[MODE_EN_BIT]   = en_q;
         bus_rdata[MODE_RST_BIT]  = rstm_q;
         bus_rdata[MODE_FLAG_BIT] = flag_q;
      end else if (hit_tc) begin
         bus_rdata = DATA_W'(tc_q);
      end else if (bus_addr == ADDR_W'(OFS_CNT)) begin
         bus_rdata = DATA_W'(count);
      end
   end

   assign wdt_rst_o = rst_q;

   // R5
   rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_o |-> $past(armed_q && rstm_q));
   // R9
   armed_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> en_q);
   // R9
   armed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |=> (armed_q && en_q && (rstm_q || !$past(rstm_q))));
   // R6
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q |=> flag_q);
   // R10
   tc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tc_q >= TC_FLOOR);
   // R11
   feed_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      good |=> !wdt_rst_o);
endmodule

// File: tb/wdg_timer_tb_top.sv
module wdg_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wdt_rst_o;

   int nchk = 0;
   int nerr = 0;
   int cyc = 0;
   bit in_rst = 1'b1;
   int    exp_q[$];
   string tag_q[$];

   localparam int PERIOD = 1024;   // 4*(0xFF+1)

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdg_timer dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .wdt_rst_o (wdt_rst_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic feed();
      bus_write(4'h8, 32'hAA);
      bus_write(4'h8, 32'h55);
   endtask

   task automatic expect_rst(input int at, input string tag);
      exp_q.push_back(at);
      tag_q.push_back(tag);
   endtask

   task automatic do_reset();
      while (exp_q.size() != 0) begin
         nchk++; nerr++;
         $display("FAIL %s: actual no pulse expected pulse at cycle %0d", tag_q[0], exp_q[0]);
         void'(exp_q.pop_front());
         void'(tag_q.pop_front());
      end
      in_rst = 1'b1;
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      in_rst = 1'b0;
   endtask

   // scoreboard monitor: compares the reset output with the expected queue
   always @(negedge clk) begin
      #2;
      if (!in_rst) begin
         while (exp_q.size() != 0 && exp_q[0] < cyc) begin
            nchk++; nerr++;
            $display("FAIL %s: actual no pulse expected pulse at cycle %0d", tag_q[0], exp_q[0]);
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
         end
         if (exp_q.size() != 0 && exp_q[0] == cyc) begin
            check(tag_q[0], {31'd0, wdt_rst_o}, 32'd1);
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
         end else if (wdt_rst_o !== 1'b0) begin
            nchk++; nerr++;
            $display("FAIL R5: actual unexpected pulse at cycle %0d expected none", cyc);
         end
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin : driver
      logic [31:0] d;
      int e0;
      idle(2);
      do_reset();

      // R1 reset state
      bus_read(4'h0, d); check("R1 mode", d, 32'h0);
      bus_read(4'h4, d); check("R1 reload", d, 32'hFF);
      bus_read(4'hC, d); check("R1 count", d, 32'hFF);
      check("R1 rst_out", {31'd0, wdt_rst_o}, 32'd0);

      // R10 clamp and truncation, deferred effect
      bus_write(4'h4, 32'h10);
      bus_read(4'h4, d); check("R10 clamp", d, 32'hFF);
      bus_write(4'h4, 32'h0100_0300);
      bus_read(4'h4, d); check("R10 truncate", d, 32'h300);
      bus_read(4'hC, d); check("R10 no early load", d, 32'hFF);

      // R9 before arming: bits writable both ways
      bus_write(4'h0, 32'h3);
      bus_read(4'h0, d); check("R9 set pre-arm", d, 32'h3);
      bus_write(4'h0, 32'h0);
      bus_read(4'h0, d); check("R9 clear pre-arm", d, 32'h0);

      // R4 enable alone does not count
      bus_write(4'h0, 32'h3);
      idle(20);
      bus_read(4'hC, d); check("R4 count frozen", d, 32'hFF);

      // R8 broken sequence when not armed: no pulse, sequence dropped
      bus_write(4'h8, 32'hAA);
      bus_write(4'h8, 32'h12);
      check("R8 no pulse unarmed", {31'd0, wdt_rst_o}, 32'd0);
      bus_write(4'h8, 32'h55);
      bus_read(4'hC, d); check("R8 lone 0x55 no reload", d, 32'hFF);
      idle(8);
      bus_read(4'hC, d); check("R8 still unarmed", d, 32'hFF);

      // R2/R3 valid feed arms and reloads
      feed();
      bus_read(4'hC, d); check("R2 reload", d, 32'h300);
      idle(3);
      bus_read(4'hC, d); check("R3 before first tick", d, 32'h300);
      idle(1);
      bus_read(4'hC, d); check("R3 first tick", d, 32'h2FF);
      idle(4);
      bus_read(4'hC, d); check("R3 second tick", d, 32'h2FE);

      // R9 after arming: zero writes ignored
      bus_write(4'h0, 32'h0);
      bus_read(4'h0, d); check("R9 locked", d, 32'h3);

      // R12 stray key byte ignored while armed
      bus_write(4'h8, 32'h12);
      check("R12 no pulse", {31'd0, wdt_rst_o}, 32'd0);
      idle(2);

      // R7 wrong second byte and foreign write
      bus_write(4'h8, 32'hAA);
      bus_write(4'h8, 32'hAA);
      expect_rst(cyc, "R7 wrong second byte");
      idle(2);
      bus_write(4'h8, 32'hAA);
      bus_write(4'h4, 32'h300);
      expect_rst(cyc, "R7 foreign write");
      idle(2);

      // R5 expiry with reset mode
      do_reset();
      bus_write(4'h0, 32'h3);
      feed();
      e0 = cyc;
      expect_rst(e0 + PERIOD, "R5 expiry pulse");
      idle(PERIOD - 1);
      bus_read(4'hC, d); check("R5 count at zero", d, 32'h0);
      idle(1);
      bus_read(4'hC, d); check("R5 reload on expiry", d, 32'hFF);
      idle(4);

      // R6 expiry without reset mode sets sticky flag
      do_reset();
      bus_write(4'h0, 32'h1);
      feed();
      idle(PERIOD);
      bus_read(4'h0, d); check("R6 flag set", d, 32'h5);
      bus_read(4'hC, d); check("R6 reload", d, 32'hFF);
      bus_write(4'h8, 32'hAA);
      bus_write(4'h8, 32'h33);
      check("R8 no pulse reset mode clear", {31'd0, wdt_rst_o}, 32'd0);
      idle(PERIOD);
      bus_read(4'h0, d); check("R6 flag sticky", d, 32'h5);

      // R11 feed completing on the expiry edge
      do_reset();
      bus_write(4'h0, 32'h3);
      feed();
      idle(PERIOD - 2);
      feed();
      check("R11 no pulse", {31'd0, wdt_rst_o}, 32'd0);
      bus_read(4'hC, d); check("R11 reloaded", d, 32'hFF);
      expect_rst(cyc + PERIOD, "R11 next expiry");
      idle(PERIOD + 4);

      do_reset();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule